// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits in front of the 8 KB private peripheral window of a processor cluster. It steers every access on a simple memory-mapped bus to one target. The targets are the cluster control-unit registers, the interrupt-controller CPU interfaces, the per-CPU timer and watchdog slices, and the interrupt distributor. Target selects come straight from the address in the same cycle. The low eight address bits go to the selected target as its internal offset. The targets answer for themselves.

The block implements the four control-unit registers itself: a one-bit control flag, a read-only configuration word built from the CPU count, a status word that reads zero, and an invalidate command that has no effect. The block also answers, one cycle later, every access that falls on the control unit or on an unmapped hole. An unmapped control-unit offset or a hole in the window produces an error pulse with zero data. The CPU count is a parameter from 1 to 4. Each bank of CPU interfaces, timers and watchdogs has one slot that aliases the requesting CPU, followed by one slot for each physical CPU.

Top module: `priv_window_decoder`

## Requirements
- R1: An access to bytes 0x000-0x0FF, or to any hole, selects no target. It gets a local response one cycle later: rsp_valid is high for one cycle per accepted access. Accesses that go to a target get no local response.
- R2: A write to control-unit offset 0x00 stores bit 0 of the write data and ignores the other bits. A read of 0x00 returns that bit in bit 0 and zeros above it.
- R3: A read of offset 0x04 returns (((1<<N)-1)<<4) | (N-1), where N is NUM_CPU. This is 0x000000F3 for N=4.
- R4: A read of offset 0x08 returns zero. A read of offset 0x0C returns zero. A write to 0x0C changes no stored state. Neither offset flags an error.
- R5: Any other control-unit offset, read or written, gives rsp_err=1 with rsp_rdata=0 and leaves the control bit unchanged.
- R6: Addresses 0x100-0x1FF raise cpuif_sel[0], the current-CPU alias. Addresses 0x200+n*0x100 up to 0x2FF+n*0x100 raise cpuif_sel[n+1], for physical CPU n < N.
- R7: For slot k from 0 to N, bytes 0x600+k*0x100 to 0x61F+k*0x100 raise tmr_sel[k], and bytes 0x620+k*0x100 to 0x63F+k*0x100 raise wdg_sel[k]. Slot 0 is the alias and slot n+1 is CPU n.
- R8: Addresses 0x1000-0x1FFF raise dist_sel.
- R9: Every other address is a hole: no select is raised, and the local response carries rsp_err=1 with rsp_rdata=0.
- R10: Selects follow req_valid and the address in the same cycle and are all low while req_valid is low. tgt_offset always equals req_addr[7:0].
- R11: At most one select, or the local response path, is active for any access.
- R12: After reset, rsp_valid and rsp_err are 0 and the control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_wdata | input | DATA_W | Write data |
| cpuif_sel | output | NUM_CPU+1 | CPU interface selects, bit 0 is the alias |
| tmr_sel | output | NUM_CPU+1 | Timer slice selects, bit 0 is the alias |
| wdg_sel | output | NUM_CPU+1 | Watchdog slice selects, bit 0 is the alias |
| dist_sel | output | 1 | Interrupt distributor select |
| tgt_offset | output | 8 | Offset inside the selected slot |
| rsp_valid | output | 1 | Local response valid |
| rsp_err | output | 1 | Local response is an error |
| rsp_rdata | output | DATA_W | Local read data |

## Verification
The assertions assume that accesses are 32-bit and word aligned. They also assume that req_addr stays inside the 13-bit window and that a new request is accepted every cycle in which req_valid is high. The stimulus only produces addresses that are multiples of four. It mixes offsets drawn from the control-unit page with addresses drawn from the whole window, and uses fixed corner addresses at the first and last word of each slot, sub-window and hole. The write data is random, so the upper bits ignored by the control register are exercised.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  // Control-unit register selector, taken from address bits [3:2]
  typedef enum logic [1:0] {
    SCU_CTRL = 2'd0,
    SCU_CFG  = 2'd1,
    SCU_STAT = 2'd2,
    SCU_INV  = 2'd3
  } scu_reg_e;

  localparam int unsigned MAX_CPU     = 4;
  localparam int unsigned SLOT_W      = 8;   // 256-byte slots
  localparam int unsigned SUB_W       = 5;   // 32-byte timer/watchdog sub-windows
  localparam int unsigned CPUIF_SLOT0 = 1;
  localparam int unsigned TMR_SLOT0   = CPUIF_SLOT0 + MAX_CPU + 1;

endpackage

// File: rtl/pwd_region_decode.sv
module pwd_region_decode
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NUM_CPU:0]  cpuif_sel,
  output logic [NUM_CPU:0]  tmr_sel,
  output logic [NUM_CPU:0]  wdg_sel,
  output logic              dist_sel,
  output logic              scu_hit,
  output logic              gap_hit
);

  localparam int unsigned IDX_W = ADDR_W - 1 - SLOT_W;
  localparam int unsigned SEL_W = SLOT_W - SUB_W;

  logic             lower_half;
  logic [IDX_W-1:0] slot_idx;
  logic [SEL_W-1:0] sub_idx;

  assign lower_half = ~req_addr[ADDR_W-1];
  assign slot_idx   = req_addr[ADDR_W-2:SLOT_W];
  assign sub_idx    = req_addr[SLOT_W-1:SUB_W];

  for (genvar k = 0; k <= NUM_CPU; k++) begin : g_slot
    logic cif_slot;
    logic tmr_slot;
    assign cif_slot     = lower_half && (slot_idx == IDX_W'(CPUIF_SLOT0 + k));
    assign tmr_slot     = lower_half && (slot_idx == IDX_W'(TMR_SLOT0 + k));
    assign cpuif_sel[k] = req_valid && cif_slot;
    assign tmr_sel[k]   = req_valid && tmr_slot && (sub_idx == SEL_W'(0));
    assign wdg_sel[k]   = req_valid && tmr_slot && (sub_idx == SEL_W'(1));
  end

  assign dist_sel = req_valid && req_addr[ADDR_W-1];
  assign scu_hit  = req_valid && lower_half && (slot_idx == '0);
  assign gap_hit  = req_valid && !(|cpuif_sel || |tmr_sel || |wdg_sel || dist_sel || scu_hit);

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpuif_sel, tmr_sel, wdg_sel, dist_sel, scu_hit, gap_hit})) else $error("multi select"); // R11
  AST_EVERY_REQ_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({cpuif_sel, tmr_sel, wdg_sel, dist_sel, scu_hit, gap_hit}) == 1) else $error("unrouted"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({cpuif_sel, tmr_sel, wdg_sel, dist_sel, scu_hit, gap_hit} == '0)) else $error("idle select"); // R10

endmodule

// File: rtl/pwd_scu_regfile.sv
module pwd_scu_regfile
  import pwd_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [SLOT_W-1:0] acc_ofs,
  input  logic              acc_wbit,
  output logic [DATA_W-1:0] rd_data,
  output logic              ofs_bad,
  output logic              ctrl_bit
);

  localparam int unsigned CFG_INT  = (((1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1);
  localparam logic [DATA_W-1:0] CFG_WORD = DATA_W'(CFG_INT);

  logic     ofs_known;
  scu_reg_e reg_sel;
  logic     ctrl_we;
  logic     ctrl_d;
  logic     ctrl_q;

  assign ofs_known = (acc_ofs[SLOT_W-1:4] == '0) && (acc_ofs[1:0] == 2'b00);
  assign reg_sel   = scu_reg_e'(acc_ofs[3:2]);
  assign ofs_bad   = acc_en && !ofs_known;
  assign ctrl_we   = acc_en && acc_wr && ofs_known && (reg_sel == SCU_CTRL);

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = acc_wbit;
  end

  // register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_data = '0;
    if (ofs_known) begin
      case (reg_sel)
        SCU_CTRL: rd_data = {{(DATA_W-1){1'b0}}, ctrl_q};
        SCU_CFG:  rd_data = CFG_WORD;
        SCU_STAT: rd_data = '0;
        SCU_INV:  rd_data = '0;
        default:  rd_data = '0;
      endcase
    end
  end

  assign ctrl_bit = ctrl_q;

  AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(acc_en && acc_wr && acc_ofs == '0)) else $error("ctrl changed"); // R5

endmodule

// File: rtl/pwd_local_resp.sv
module pwd_local_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_en,
  input  logic              loc_err,
  input  logic [DATA_W-1:0] loc_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic              vld_d, err_d, dat_en;
  logic              vld_q, err_q;
  logic [DATA_W-1:0] dat_d, dat_q;

  always_comb begin
    vld_d  = loc_en;
    err_d  = loc_en && loc_err;
    dat_d  = (loc_en && !loc_err) ? loc_rdata : '0;
    dat_en = loc_en || vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_d;
  end

  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = dat_q;

  AST_ERR_HAS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0)) else $error("err data"); // R5
  AST_ERR_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid) else $error("err w/o valid"); // R9

endmodule

// File: rtl/priv_window_decoder.sv
module priv_window_decoder
  import pwd_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [NUM_CPU:0]  cpuif_sel,
  output logic [NUM_CPU:0]  tmr_sel,
  output logic [NUM_CPU:0]  wdg_sel,
  output logic              dist_sel,
  output logic [SLOT_W-1:0] tgt_offset,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic              scu_hit, gap_hit;
  logic              ofs_bad, ctrl_bit;
  logic [DATA_W-1:0] reg_rdata;
  logic              loc_en, loc_err;
  logic [DATA_W-1:0] loc_rdata;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:1];

  pwd_region_decode #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .cpuif_sel (cpuif_sel),
    .tmr_sel   (tmr_sel),
    .wdg_sel   (wdg_sel),
    .dist_sel  (dist_sel),
    .scu_hit   (scu_hit),
    .gap_hit   (gap_hit)
  );

  pwd_scu_regfile #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (scu_hit),
    .acc_wr   (req_write),
    .acc_ofs  (req_addr[SLOT_W-1:0]),
    .acc_wbit (req_wdata[0]),
    .rd_data  (reg_rdata),
    .ofs_bad  (ofs_bad),
    .ctrl_bit (ctrl_bit)
  );

  assign loc_en    = scu_hit || gap_hit;
  assign loc_err   = gap_hit || ofs_bad;
  assign loc_rdata = req_write ? '0 : reg_rdata;

  pwd_local_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_en    (loc_en),
    .loc_err   (loc_err),
    .loc_rdata (loc_rdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  assign tgt_offset = req_addr[SLOT_W-1:0];

  AST_RSP_FOLLOWS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !dist_sel && !(|cpuif_sel) && !(|tmr_sel) && !(|wdg_sel))) else $error("stray rsp"); // R1
  AST_CTRL_LOADS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == '0) |=> (ctrl_bit == $past(req_wdata[0]))) else $error("ctrl load"); // R2

endmodule

// File: tb/sim_priv_window_decoder.sv
`timescale 1ns/1ps
module sim_priv_window_decoder;

  localparam int N  = 4;
  localparam int AW = 13;
  localparam int DW = 32;
  localparam int SW = 3*(N+1)+1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [N:0]    cpuif_sel, tmr_sel, wdg_sel;
  logic          dist_sel;
  logic [7:0]    tgt_offset;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  bit  ctrl_m  = 0;

  always #2.5 clk = ~clk;

  priv_window_decoder #(.NUM_CPU(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cpuif_sel(cpuif_sel),
    .tmr_sel(tmr_sel), .wdg_sel(wdg_sel), .dist_sel(dist_sel),
    .tgt_offset(tgt_offset), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  function automatic logic [SW-1:0] exp_sel(int a);
    logic [N:0] c = '0, t = '0, w = '0;
    logic d = 0;
    int slot = a / 256;
    int off  = a % 256;
    if (a >= 4096) d = 1;
    else if (slot >= 1 && slot <= N + 1) c[slot-1] = 1;
    else if (slot >= 6 && slot <= 6 + N) begin
      if (off < 32)      t[slot-6] = 1;
      else if (off < 64) w[slot-6] = 1;
    end
    return {d, w, t, c};
  endfunction

  function automatic bit is_local(int a);
    return (exp_sel(a) == '0);
  endfunction

  function automatic bit exp_err(int a);
    if (!is_local(a)) return 0;
    if (a >= 256) return 1;
    return !(a == 0 || a == 4 || a == 8 || a == 12);
  endfunction

  function automatic logic [DW-1:0] exp_rd(int a, bit wr);
    if (!is_local(a) || exp_err(a) || wr) return '0;
    if (a == 0) return {31'b0, ctrl_m};
    if (a == 4) return ((((1 << N) - 1) << 4) | (N - 1));
    return '0;
  endfunction

  function automatic string tag_of(int a);
    int slot = a / 256;
    if (a >= 4096) return "R8";
    if (slot == 0) return exp_err(a) ? "R5" : "R1";
    if (slot <= N + 1) return "R6";
    if (slot >= 6 && slot <= 6 + N && (a % 256) < 64) return "R7";
    return "R9";
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, int a, logic [DW-1:0] wd, string req);
    logic [DW-1:0] erd;
    bit            eloc, eerr;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
    #1;
    check(req, "select", 64'({dist_sel, wdg_sel, tmr_sel, cpuif_sel}), 64'(exp_sel(a)));
    check("R10", "offset", 64'(tgt_offset), 64'(a % 256));
    erd = exp_rd(a, wr); eloc = is_local(a); eerr = exp_err(a);
    @(posedge clk); #1;
    check(req, "response", {rsp_valid, rsp_err, 30'b0, rsp_rdata}, {eloc, eerr, 30'b0, erd});
    if (wr && a == 0) ctrl_m = wd[0];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    void'($urandom(32'h5eed1));
    repeat (3) @(posedge clk);
    #1;
    check("R12", "reset rsp", {rsp_valid, rsp_err}, 2'b00);
    @(negedge clk); rst_n = 1;

    access(0, 'h000, '0, "R12");
    access(0, 'h004, '0, "R3");
    access(1, 'h004, '1, "R3");
    access(0, 'h004, '0, "R3");
    access(0, 'h008, '0, "R4");
    access(1, 'h000, 32'hFFFF_FFFF, "R2");
    access(1, 'h00C, 32'h0000_0000, "R4");
    access(0, 'h00C, '0, "R4");
    access(0, 'h000, '0, "R4");
    access(1, 'h000, 32'hFFFF_FFFE, "R2");
    access(0, 'h000, '0, "R2");
    access(1, 'h000, 32'h0000_0001, "R2");
    access(1, 'h010, 32'h0000_0000, "R5");
    access(1, 'h0FC, 32'h0000_0000, "R5");
    access(0, 'h0FC, '0, "R5");
    access(0, 'h000, '0, "R5");
    access(0, 'h100, '0, "R6");
    access(1, 'h1FC, '1, "R6");
    access(0, 'h200, '0, "R6");
    access(0, 'h5FC, '0, "R6");
    access(0, 'h600, '0, "R7");
    access(0, 'h61C, '0, "R7");
    access(1, 'h620, '0, "R7");
    access(0, 'h63C, '0, "R7");
    access(0, 'hA00, '0, "R7");
    access(0, 'hA3C, '0, "R7");
    access(0, 'h640, '0, "R9");
    access(1, 'hB00, '0, "R9");
    access(0, 'hFFC, '0, "R9");
    access(0, 'h1000, '0, "R8");
    access(1, 'h1FFC, '0, "R8");

    // idle cycle: selects and response stay quiet
    @(negedge clk);
    req_valid = 0; req_addr = AW'('h100);
    #1;
    check("R10", "idle select", 64'({dist_sel, wdg_sel, tmr_sel, cpuif_sel}), 64'(0));
    @(posedge clk); #1;
    check("R1", "idle rsp", {rsp_valid, rsp_err}, 2'b00);

    for (int i = 0; i < 600; i++) begin
      int a;
      if ($urandom % 3 == 0) a = ($urandom % 64) * 4;
      else                   a = ($urandom % 2048) * 4;
      access(bit'($urandom % 2), a, $urandom, tag_of(a));
    end

    @(negedge clk); req_valid = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule